// File: doc/BRIEF.md
# NOR Flash Command Sequence Controller

This block sits behind an asynchronous flash-style bus (chip enable, write enable, output enable, reset and a 16-bit data bus) and turns multi-cycle bus write sequences into internally timed operations on a small on-chip memory model. It supports three operations: word program, sector erase and chip erase. It also keeps a status-configuration register. Each operation's duration comes from a parameterized clock-cycle counter, so no real analog timing is modelled. A per-sector lock map arrives on an input vector. An erase aimed at a locked sector fails at once, and chip erase passes over locked sectors.

The bus strobes are brought into the clock domain through a two-stage synchronizer. A write cycle is active while CE and WE are both low and OE is high. The address is taken when that condition begins, which is the later of the two falling edges. The data is taken when the condition ends, which is the first of the two rising edges. A sequence decoder walks these states: `D_IDLE`, `D_KEY1` (first unlock seen), `D_KEY2` (second unlock seen), then one of `D_PROG_ARG`, `D_CFG_ARG` or `D_ERS_CMD`. From `D_ERS_CMD` it goes on through `D_ERS_KEY1` and `D_ERS_KEY2`. Any cycle that does not match the expected pattern returns it to `D_IDLE`.

The operation engine has four states:
- `E_READY` is the read state.
- `E_PROG` and `E_ERASE` count down the operation time.
- `E_HOLD` is entered after a failure, or after a success when the configuration value is 01. It is left by an exit write.

Each engine transition is covered in the requirements below. The status bit formatting is done by a separate block, which uses `status_sel`, `busy`, `op_fail` and `cfg_mode`.

Top module: `flash_seq_ctrl`

## Requirements
- R1: The address of a write cycle is the value present when the later of the CE/WE falling edges occurs (CE low, WE low, OE high). Address changes before that edge, or after it, have no effect.
- R2: The data of a write cycle is the value present at the first of the CE/WE rising edges. Data changes after that edge have no effect.
- R3: Word program is four cycles: 555h/AAh, 2AAh/55h, 555h/A0h, then target/data. After the fourth cycle `busy` is 1 for PROG_CYC clocks. The word then holds old AND data.
- R4: Sector erase is six cycles: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then SA/30h. The sector index is addr[ADDR_W-1:2] with four words per sector. After ERASE time that sector's words read FFFFh, and other sectors are unchanged.
- R5: Chip erase uses the same first five cycles and then 555h/10h. Every sector whose `sector_lock` bit is 0 becomes FFFFh. Locked sectors keep their contents.
- R6: A sector erase aimed at a locked sector, or at an index of 71 or more, never raises `busy`. It sets `op_fail`=1 and `status_sel`=1 with memory unchanged. Both flags remain until a write of F0h to any address, which returns the block to read mode.
- R7: Bus writes received while `busy` is 1 are ignored, including full command sequences.
- R8: While `bus_rst_n` is 0, the running operation is aborted without a memory write and `data_oe` is 0. After release, the block is in read mode with `busy`, `op_fail` and `status_sel` at 0, and `cfg_mode` is unchanged.
- R9: The configuration write is 555h/AAh, 2AAh/55h, 555h/D0h, then any address with value 00h or 01h. Other values are ignored, and `por_n` resets the register to 00. With 01, a successful operation ends in `status_sel`=1 with `busy`=0 until an F0h write.
- R10: A cycle whose address or code does not match the expected pattern returns the decoder to idle, and the broken sequence has no effect.
- R11: Data bits 15:8 are ignored when command codes are decoded.
- R12: `data_oe` = CE low, OE low, WE high and `bus_rst_n` high. `rdata` is the addressed word, or FFFFh for addresses of 284 or more. Memory reads FFFFh after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including configuration and memory |
| bus_rst_n | input | 1 | Bus reset pin, active low; aborts the operation, keeps configuration |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| sector_lock | input | NSEC | Per-sector protection map, 1 = locked |
| rdata | output | DATA_W | Read data of the addressed word |
| data_oe | output | 1 | Drive enable for the external data bus buffer |
| busy | output | 1 | Program or erase in progress |
| op_fail | output | 1 | Last operation failed |
| status_sel | output | 1 | Read path should show status instead of memory |
| cfg_mode | output | 2 | Status-configuration register value |

## Verification
A bus write cycle can end while an embedded program is still counting toward the clock in which it writes memory. A complete second program sequence can therefore finish in the same window that the engine retires the first. The bench provokes this by issuing the second sequence at once, well inside the PROG_CYC window. It judges the result by reading both words afterwards: only the first may have changed. A bus reset landing during a running program is provoked in the same way, and is judged by the target word still reading erased while `cfg_mode` keeps its earlier value.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    typedef enum logic [2:0] {OP_NONE, OP_PROG, OP_SERASE, OP_CERASE, OP_CFG} op_kind_t;

    localparam int unsigned KEY_ADDR_A = 'h555;
    localparam int unsigned KEY_ADDR_B = 'h2AA;
    localparam logic [7:0]  KEY_CODE_A = 8'hAA;
    localparam logic [7:0]  KEY_CODE_B = 8'h55;
    localparam logic [7:0]  CODE_PROG  = 8'hA0;
    localparam logic [7:0]  CODE_ERASE = 8'h80;
    localparam logic [7:0]  CODE_CFG   = 8'hD0;
    localparam logic [7:0]  CODE_SECT  = 8'h30;
    localparam logic [7:0]  CODE_CHIP  = 8'h10;
    localparam logic [7:0]  CODE_EXIT  = 8'hF0;
endpackage

// File: rtl/fsc_bus_capture.sv
module fsc_bus_capture #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              evt,
    output logic [ADDR_W-1:0] evt_addr,
    output logic [DATA_W-1:0] evt_data
);
    logic [2:0] ce_p, we_p, oe_p;
    logic [ADDR_W-1:0] a1, a2, lat_addr;
    logic [DATA_W-1:0] d1, d2, d3;
    logic act2, act3;

    assign act2 = !ce_p[1] && !we_p[1] && oe_p[1];
    assign act3 = !ce_p[2] && !we_p[2] && oe_p[2];

    always_ff @(posedge clk) begin
        if (clr) begin
            ce_p <= '1; we_p <= '1; oe_p <= '1;
            a1 <= '0; a2 <= '0; lat_addr <= '0;
            d1 <= '0; d2 <= '0; d3 <= '0;
            evt <= 1'b0; evt_addr <= '0; evt_data <= '0;
        end else begin
            ce_p <= {ce_p[1:0], ce_n};
            we_p <= {we_p[1:0], we_n};
            oe_p <= {oe_p[1:0], oe_n};
            a1 <= addr; a2 <= a1;
            d1 <= wdata; d2 <= d1; d3 <= d2;
            // later falling edge of the two strobes: take the address (R1)
            if (act2 && !act3) lat_addr <= a2;
            // first rising edge: take the data and emit the cycle (R2)
            evt <= !act2 && act3;
            if (!act2 && act3) begin
                evt_addr <= lat_addr;
                evt_data <= d3;
            end
        end
    end

    p_evt_pulse_r2: assert property (@(posedge clk) disable iff (clr)
        evt |=> !evt);
endmodule

// File: rtl/fsc_cmd_decoder.sv
module fsc_cmd_decoder
    import fsc_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [DATA_W-1:0] evt_data,
    input  logic              ready,
    output logic              launch,
    output op_kind_t          launch_op,
    output logic [ADDR_W-1:0] launch_addr,
    output logic [DATA_W-1:0] launch_data
);
    typedef enum logic [2:0] {
        D_IDLE, D_KEY1, D_KEY2, D_PROG_ARG, D_CFG_ARG, D_ERS_CMD, D_ERS_KEY1, D_ERS_KEY2
    } dec_state_t;

    dec_state_t st, nxt;
    op_kind_t   lop;
    logic [7:0] code;
    logic       at_a, at_b, key1, key2;

    assign code = evt_data[7:0];   // R11: upper byte not decoded
    assign at_a = (evt_addr == ADDR_W'(KEY_ADDR_A));
    assign at_b = (evt_addr == ADDR_W'(KEY_ADDR_B));
    assign key1 = at_a && (code == KEY_CODE_A);
    assign key2 = at_b && (code == KEY_CODE_B);

    always_comb begin
        nxt = st;
        lop = OP_NONE;
        if (!ready) begin
            nxt = D_IDLE;                       // R7: writes while not ready dropped
        end else if (evt) begin
            unique case (st)
                D_IDLE:     nxt = key1 ? D_KEY1 : D_IDLE;
                D_KEY1:     nxt = key2 ? D_KEY2 : D_IDLE;
                D_KEY2: begin
                    if (at_a && code == CODE_PROG)       nxt = D_PROG_ARG;
                    else if (at_a && code == CODE_ERASE) nxt = D_ERS_CMD;
                    else if (at_a && code == CODE_CFG)   nxt = D_CFG_ARG;
                    else                                 nxt = D_IDLE;   // R10
                end
                D_PROG_ARG: begin lop = OP_PROG; nxt = D_IDLE; end
                D_CFG_ARG:  begin lop = OP_CFG;  nxt = D_IDLE; end
                D_ERS_CMD:  nxt = key1 ? D_ERS_KEY1 : D_IDLE;
                D_ERS_KEY1: nxt = key2 ? D_ERS_KEY2 : D_IDLE;
                D_ERS_KEY2: begin
                    if (code == CODE_SECT)              lop = OP_SERASE;
                    else if (at_a && code == CODE_CHIP) lop = OP_CERASE;
                    nxt = D_IDLE;
                end
                default:    nxt = D_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (clr) st <= D_IDLE;
        else     st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            launch <= 1'b0; launch_op <= OP_NONE;
            launch_addr <= '0; launch_data <= '0;
        end else begin
            launch      <= (lop != OP_NONE);
            launch_op   <= lop;
            launch_addr <= evt_addr;
            launch_data <= evt_data;
        end
    end

    p_launch_ready_r7: assert property (@(posedge clk) disable iff (clr)
        launch |-> ready);
endmodule

// File: rtl/fsc_op_engine.sv
module fsc_op_engine
    import fsc_pkg::*;
#(
    parameter int NSEC       = 71,
    parameter int WPS        = 4,
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 16,
    parameter int PROG_CYC   = 2000,
    parameter int SERASE_CYC = 20000,
    parameter int CERASE_CYC = 60000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_rst_n,
    input  logic              launch,
    input  op_kind_t          launch_op,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [DATA_W-1:0] launch_data,
    input  logic              evt,
    input  logic [7:0]        evt_code,
    input  logic [NSEC-1:0]   sector_lock,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              ready,
    output logic              busy,
    output logic              op_fail,
    output logic              status_sel,
    output logic [1:0]        cfg_mode,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH    = NSEC * WPS;
    localparam int WBITS    = $clog2(WPS);
    localparam int IDX_W    = $clog2(DEPTH);
    localparam int SEC_W    = ADDR_W - WBITS;
    localparam int SEC_SPAN = 1 << SEC_W;
    localparam int MAX_CYC  = (CERASE_CYC > SERASE_CYC)
                            ? ((CERASE_CYC > PROG_CYC) ? CERASE_CYC : PROG_CYC)
                            : ((SERASE_CYC > PROG_CYC) ? SERASE_CYC : PROG_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    typedef enum logic [1:0] {E_READY, E_PROG, E_ERASE, E_HOLD} eng_state_t;

    eng_state_t        st;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] tgt;
    logic [DATA_W-1:0] wd;
    logic              chip;
    logic [SEC_SPAN-1:0] lock_ext;
    logic [SEC_W-1:0]  l_sec, t_sec;

    // indexes beyond the last sector count as locked (R6)
    assign lock_ext = {{(SEC_SPAN-NSEC){1'b1}}, sector_lock};
    assign l_sec    = launch_addr[ADDR_W-1:WBITS];
    assign t_sec    = tgt[ADDR_W-1:WBITS];

    always_ff @(posedge clk) begin
        if (!por_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
            st <= E_READY; cfg_mode <= 2'b00; op_fail <= 1'b0;
            cnt <= '0; tgt <= '0; wd <= '0; chip <= 1'b0;
        end else if (!bus_rst_n) begin
            st <= E_READY; op_fail <= 1'b0; cnt <= '0;    // R8 abort
        end else begin
            unique case (st)
                E_READY: if (launch) begin
                    unique case (launch_op)
                        OP_PROG: begin
                            st <= E_PROG; tgt <= launch_addr; wd <= launch_data;
                            cnt <= CNT_W'(PROG_CYC - 1);
                        end
                        OP_SERASE: begin
                            tgt <= launch_addr; chip <= 1'b0;
                            if (lock_ext[l_sec]) begin
                                st <= E_HOLD; op_fail <= 1'b1;
                            end else begin
                                st <= E_ERASE; cnt <= CNT_W'(SERASE_CYC - 1);
                            end
                        end
                        OP_CERASE: begin
                            st <= E_ERASE; chip <= 1'b1;
                            cnt <= CNT_W'(CERASE_CYC - 1);
                        end
                        OP_CFG: if (launch_data[7:1] == 7'd0) cfg_mode <= {1'b0, launch_data[0]};
                        default: ;
                    endcase
                end
                E_PROG, E_ERASE: begin
                    if (cnt == '0) begin
                        if (st == E_PROG) begin
                            if (tgt < ADDR_W'(DEPTH))
                                mem[tgt[IDX_W-1:0]] <= mem[tgt[IDX_W-1:0]] & wd;
                        end else begin
                            for (int i = 0; i < DEPTH; i++)
                                if (chip ? !sector_lock[i / WPS] : (t_sec == SEC_W'(i / WPS)))
                                    mem[i] <= '1;
                        end
                        st <= cfg_mode[0] ? E_HOLD : E_READY;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                E_HOLD: if (evt && evt_code == CODE_EXIT) begin
                    st <= E_READY; op_fail <= 1'b0;
                end
                default: st <= E_READY;
            endcase
        end
    end

    assign ready      = (st == E_READY);
    assign busy       = (st == E_PROG) || (st == E_ERASE);
    assign status_sel = (st != E_READY);
    assign rd_word    = (rd_addr < ADDR_W'(DEPTH)) ? mem[rd_addr[IDX_W-1:0]] : '1;

    p_busy_nofail_r6: assert property (@(posedge clk) disable iff (!por_n)
        busy |-> !op_fail);
    p_prot_reject_r6: assert property (@(posedge clk) disable iff (!por_n || !bus_rst_n)
        (ready && launch && launch_op == OP_SERASE && lock_ext[l_sec]) |=> (!busy && op_fail));
    p_reset_abort_r8: assert property (@(posedge clk) disable iff (!por_n)
        !bus_rst_n |=> (!busy && !status_sel));
    p_cfg_keep_r8: assert property (@(posedge clk) disable iff (!por_n)
        !bus_rst_n |=> $stable(cfg_mode));
    p_cfg_filter_r9: assert property (@(posedge clk) disable iff (!por_n || !bus_rst_n)
        (launch && launch_op == OP_CFG && launch_data[7:0] > 8'd1) |=> $stable(cfg_mode));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import fsc_pkg::*;
#(
    parameter int NSEC       = 71,
    parameter int WPS        = 4,
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 16,
    parameter int PROG_CYC   = 2000,
    parameter int SERASE_CYC = 20000,
    parameter int CERASE_CYC = 60000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSEC-1:0]   sector_lock,
    output logic [DATA_W-1:0] rdata,
    output logic              data_oe,
    output logic              busy,
    output logic              op_fail,
    output logic              status_sel,
    output logic [1:0]        cfg_mode
);
    logic              clr, evt, launch, ready;
    logic [ADDR_W-1:0] evt_addr, launch_addr;
    logic [DATA_W-1:0] evt_data, launch_data;
    op_kind_t          launch_op;

    assign clr = !por_n || !bus_rst_n;

    fsc_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .clr(clr), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata),
        .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data)
    );

    fsc_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk(clk), .clr(clr), .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data),
        .ready(ready), .launch(launch), .launch_op(launch_op),
        .launch_addr(launch_addr), .launch_data(launch_data)
    );

    fsc_op_engine #(
        .NSEC(NSEC), .WPS(WPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PROG_CYC(PROG_CYC), .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC)
    ) u_eng (
        .clk(clk), .por_n(por_n), .bus_rst_n(bus_rst_n),
        .launch(launch), .launch_op(launch_op), .launch_addr(launch_addr),
        .launch_data(launch_data), .evt(evt), .evt_code(evt_data[7:0]),
        .sector_lock(sector_lock), .rd_addr(addr),
        .ready(ready), .busy(busy), .op_fail(op_fail), .status_sel(status_sel),
        .cfg_mode(cfg_mode), .rd_word(rdata)
    );

    assign data_oe = bus_rst_n && !ce_n && !oe_n && we_n;
endmodule

// File: tb/sim_flash_seq_ctrl.sv
module sim_flash_seq_ctrl;
    localparam int AW = 11;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          por_n = 1'b0, bus_rst_n = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [70:0]   lock = '0;
    logic [DW-1:0] rdata;
    logic          data_oe, busy, op_fail, status_sel;
    logic [1:0]    cfg_mode;
    int            checks = 0, errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    flash_seq_ctrl #(.PROG_CYC(120), .SERASE_CYC(80), .CERASE_CYC(100)) u0 (
        .clk(clk), .por_n(por_n), .bus_rst_n(bus_rst_n), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .wdata(wdata), .sector_lock(lock), .rdata(rdata),
        .data_oe(data_oe), .busy(busy), .op_fail(op_fail), .status_sel(status_sel),
        .cfg_mode(cfg_mode)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; wdata = d; tick(1);
        ce_n = 1'b0; we_n = 1'b0; tick(4);
        we_n = 1'b1; tick(1);
        ce_n = 1'b1; tick(4);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; tick(1);
        v = rdata;
        ce_n = 1'b1; oe_n = 1'b1; tick(1);
    endtask

    task automatic keys();
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
        keys(); wr(11'h555, 16'h00A0); wr(a, d);
    endtask

    task automatic erase6(input logic [AW-1:0] a, input logic [DW-1:0] c);
        keys(); wr(11'h555, 16'h0080); keys(); wr(a, c);
    endtask

    task automatic setcfg(input logic [DW-1:0] v);
        keys(); wr(11'h555, 16'h00D0); wr(11'h000, v);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) tick(1);
    endtask

    task automatic expect_word(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] e);
        logic [DW-1:0] v;
        rd(a, v);
        chk(tag, {16'h0, v}, {16'h0, e});
    endtask

    task automatic t_reset();
        chk("R12 reset data_oe", data_oe, 0);
        chk("R9 reset cfg", cfg_mode, 0);
        chk("R6 reset status_sel/fail/busy", {status_sel, op_fail, busy}, 0);
        expect_word("R12 erased after power-up", 11'd0, 16'hFFFF);
    endtask

    task automatic t_read();
        logic [DW-1:0] v;
        expect_word("R12 out-of-range word", 11'd284, 16'hFFFF);
        addr = 11'd3; ce_n = 1'b0; oe_n = 1'b0; tick(1);
        chk("R12 data_oe on read", data_oe, 1);
        oe_n = 1'b1; tick(1);
        chk("R12 data_oe off with OE high", data_oe, 0);
        ce_n = 1'b1; tick(1);
        rd(11'd3, v);
    endtask

    task automatic t_program();
        prog(11'd21, 16'hFF0F);
        chk("R3 busy during program", busy, 1);
        wait_idle();
        expect_word("R3 first program", 11'd21, 16'hFF0F);
        prog(11'd21, 16'hF0FF);
        wait_idle();
        expect_word("R3 program ANDs", 11'd21, 16'hF00F);
        expect_word("R3 neighbour untouched", 11'd22, 16'hFFFF);
    endtask

    task automatic t_addr_latch();
        keys(); wr(11'h555, 16'h00A0);
        addr = 11'd30; wdata = 16'h1234; tick(1);
        we_n = 1'b0; tick(3);
        addr = 11'd25; tick(3);
        ce_n = 1'b0; tick(4);
        addr = 11'd30; tick(2);
        we_n = 1'b1; tick(1); ce_n = 1'b1; tick(4);
        wait_idle();
        expect_word("R1 later falling edge address", 11'd25, 16'h1234);
        expect_word("R1 early address unused", 11'd30, 16'hFFFF);
    endtask

    task automatic t_data_latch();
        keys(); wr(11'h555, 16'h00A0);
        addr = 11'd26; wdata = 16'h5A5A; tick(1);
        ce_n = 1'b0; we_n = 1'b0; tick(4);
        ce_n = 1'b1; tick(4);
        wdata = 16'h0000; tick(4);
        we_n = 1'b1; tick(4);
        wait_idle();
        expect_word("R2 first rising edge data", 11'd26, 16'h5A5A);
    endtask

    task automatic t_ignored();
        prog(11'd40, 16'h0000);
        prog(11'd41, 16'h0000);
        chk("R7 still busy after second sequence", busy, 1);
        wait_idle();
        expect_word("R7 first program done", 11'd40, 16'h0000);
        expect_word("R7 write during busy ignored", 11'd41, 16'hFFFF);
    endtask

    task automatic t_sector_erase();
        prog(11'd44, 16'h1111); wait_idle();
        prog(11'd45, 16'h2222); wait_idle();
        prog(11'd48, 16'h3333); wait_idle();
        erase6(11'd46, 16'h0030);
        chk("R4 busy during erase", busy, 1);
        wait_idle();
        expect_word("R4 sector word0 erased", 11'd44, 16'hFFFF);
        expect_word("R4 sector word1 erased", 11'd45, 16'hFFFF);
        expect_word("R4 other sector kept", 11'd48, 16'h3333);
    endtask

    task automatic t_protect();
        lock[12] = 1'b1;
        erase6(11'd48, 16'h0030);
        chk("R6 no busy, fail, status", {busy, op_fail, status_sel}, 3'b011);
        expect_word("R6 locked sector unchanged", 11'd48, 16'h3333);
        wr(11'h000, 16'h00F0);
        chk("R6 exit clears", {op_fail, status_sel}, 0);
    endtask

    task automatic t_chip();
        prog(11'd12, 16'h0F0F); wait_idle();
        erase6(11'h555, 16'h0010);
        chk("R5 busy during chip erase", busy, 1);
        wait_idle();
        expect_word("R5 unlocked erased", 11'd12, 16'hFFFF);
        expect_word("R5 unlocked erased 2", 11'd40, 16'hFFFF);
        expect_word("R5 locked kept", 11'd48, 16'h3333);
        lock = '0;
    endtask

    task automatic t_cfg();
        setcfg(16'h0001);
        chk("R9 cfg set 01", cfg_mode, 1);
        setcfg(16'h0002);
        chk("R9 illegal value ignored", cfg_mode, 1);
        prog(11'd60, 16'h00FF);
        wait_idle();
        chk("R9 hold after success", {busy, op_fail, status_sel}, 3'b001);
        wr(11'h000, 16'h00F0);
        chk("R9 exit returns to read", status_sel, 0);
        expect_word("R9 program result", 11'd60, 16'h00FF);
    endtask

    task automatic t_bus_reset();
        prog(11'd64, 16'h0000);
        tick(10);
        chk("R8 busy before reset", busy, 1);
        bus_rst_n = 1'b0; addr = 11'd64; ce_n = 1'b0; oe_n = 1'b0; tick(2);
        chk("R8 outputs off in reset", data_oe, 0);
        ce_n = 1'b1; oe_n = 1'b1; bus_rst_n = 1'b1; tick(2);
        chk("R8 idle after reset", {busy, op_fail, status_sel}, 0);
        chk("R8 cfg kept", cfg_mode, 1);
        tick(200);
        expect_word("R8 aborted program no write", 11'd64, 16'hFFFF);
        setcfg(16'h0000);
        chk("R9 cfg back to 00", cfg_mode, 0);
    endtask

    task automatic t_mismatch();
        keys(); wr(11'h123, 16'h00A0); wr(11'd68, 16'h0000);
        tick(4);
        chk("R10 broken sequence no busy", busy, 0);
        expect_word("R10 broken sequence no write", 11'd68, 16'hFFFF);
        wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055); wr(11'h555, 16'h00A0); wr(11'd69, 16'h0000);
        tick(4);
        expect_word("R10 wrong unlock address no write", 11'd69, 16'hFFFF);
        prog(11'd69, 16'h0000); wait_idle();
        expect_word("R10 recovers for valid sequence", 11'd69, 16'h0000);
    endtask

    task automatic t_upper();
        wr(11'h555, 16'h12AA); wr(11'h2AA, 16'hFF55); wr(11'h555, 16'h33A0); wr(11'd72, 16'h0F0F);
        wait_idle();
        expect_word("R11 upper byte ignored", 11'd72, 16'h0F0F);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        tick(5);
        por_n = 1'b1;
        tick(3);
        t_reset();
        t_read();
        t_program();
        t_addr_latch();
        t_data_latch();
        t_ignored();
        t_sector_erase();
        t_protect();
        t_chip();
        t_cfg();
        t_bus_reset();
        t_mismatch();
        t_upper();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule